// File: doc/BRIEF.md
# Dual-Clock Mailbox Pair with Full Flags

This block carries short command words between two ports that run on unrelated clocks. It sits beside a FIFO. Port A can deposit one word in the forward mailbox for port B to collect. Port B can deposit one word in the return mailbox for port A to collect. Each port has a select input that steers an enabled transfer either to its mailbox or to the FIFO. For FIFO transfers the block only produces the FIFO write or read strobe. The FIFO storage and the bus drivers live outside the block.

Each mailbox has an active-low flag in the writer's clock domain. A low flag means a word is waiting. A write is accepted only while the flag is high, and an accepted write pulls it low. When the reader collects the word, the flag returns high. Between the two domains, each mailbox uses a toggle request and a toggle acknowledge, each crossing through a two-flop synchronizer. The register contents survive a read and change only on the next accepted write.

The port-B read data is either the FIFO output register or the forward mailbox, chosen by port B's select. The port-A read data is always the return mailbox.

Top module: `mbx_dual`

## Requirements
- R1: An enabled port-A write (a_en=1, a_wr=1) with a_mbsel=1 while mb1_flag is high stores a_din in the forward mailbox on that rising clk_a edge.
- R2: An enabled port-B write (b_en=1, b_wr=1) with b_mbsel=1 while mb2_flag is high stores b_din in the return mailbox on that rising clk_b edge.
- R3: An accepted mailbox write drives that mailbox's flag low from the same writer clock edge.
- R4: A mailbox write attempted while that mailbox's flag is low changes neither the stored word nor the flag.
- R5: A read of a waiting word by the other port returns the flag high within three writer clock edges. The read is enabled with wr=0 and mbsel=1, and takes place at least three reader clock edges after the write. A read with no waiting word has no effect.
- R6: Reading a mailbox leaves its contents unchanged.
- R7: b_dout equals fifo_q while b_mbsel=0 and equals the forward mailbox while b_mbsel=1.
- R8: a_dout always equals the return mailbox.
- R9: After reset both flags are high and both mailboxes hold zero.
- R10: a_fifo_wr is high exactly when a_en=1, a_wr=1 and a_mbsel=0. b_fifo_rd is high exactly when b_en=1, b_wr=0 and b_mbsel=0. Mailbox transfers raise neither strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port-A clock |
| clk_b | input | 1 | Port-B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_en | input | 1 | Port-A transfer enable |
| a_wr | input | 1 | Port-A direction, 1 = write, 0 = read |
| a_mbsel | input | 1 | Port-A target, 1 = mailbox, 0 = FIFO |
| a_din | input | DATA_W | Port-A write data |
| a_dout | output | DATA_W | Port-A read data (return mailbox) |
| a_fifo_wr | output | 1 | FIFO write strobe from port A |
| mb1_flag | output | 1 | Forward mailbox flag, low = word waiting (clk_a domain) |
| b_en | input | 1 | Port-B transfer enable |
| b_wr | input | 1 | Port-B direction, 1 = write, 0 = read |
| b_mbsel | input | 1 | Port-B target, 1 = mailbox, 0 = FIFO |
| b_din | input | DATA_W | Port-B write data |
| fifo_q | input | DATA_W | FIFO output register contents |
| b_dout | output | DATA_W | Port-B read data |
| b_fifo_rd | output | 1 | FIFO read strobe from port B |
| mb2_flag | output | 1 | Return mailbox flag, low = word waiting (clk_b domain) |

## Verification
The bench builds the block with DATA_W=8 and keeps the two-stage synchronizer. At that width it can pass every one of the 256 data values through each mailbox in turn. On every pass it also tries a refused overwrite with the complemented value, so a stuck or leaking data bit is exposed in both directions. The port clocks are unrelated, at 10 ns and 13 ns, so the handshake crossings land at shifting phase offsets across the sweep. The output multiplexer and the FIFO strobes are checked over a sweep of fifo_q values and all combinations of enable, direction and select.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Reader-side handshake state
    typedef struct packed {
        logic ack;
    } rd_state_t;

    // A toggle pair that differs means a word is in flight
    function automatic logic tgl_open(input logic req, input logic ack);
        return req ^ ack;
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d;
        end else begin : g_chain
            always_comb sh_d = {sh_q[LAST-1:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[LAST];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int STAGES = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_req,
    output logic [DATA_W-1:0] mail,
    output logic              flag_w
);
    typedef struct packed {
        logic [DATA_W-1:0] mail;
        logic              req;
    } wr_state_t;

    wr_state_t w_d, w_q;
    rd_state_t r_d, r_q;
    logic      ack_at_w, req_at_r, pending_r;

    // Writer domain
    mbx_sync #(.STAGES(STAGES)) i_ack_sync (
        .clk(wclk), .rst_n(rst_n), .d(r_q.ack), .q(ack_at_w)
    );

    assign flag_w = !tgl_open(w_q.req, ack_at_w);

    always_comb begin
        w_d = w_q;
        if (wr_req && flag_w) begin
            w_d.mail = wdata;
            w_d.req  = !w_q.req;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    // Reader domain
    mbx_sync #(.STAGES(STAGES)) i_req_sync (
        .clk(rclk), .rst_n(rst_n), .d(w_q.req), .q(req_at_r)
    );

    assign pending_r = tgl_open(req_at_r, r_q.ack);

    always_comb begin
        r_d = r_q;
        if (rd_req && pending_r) r_d.ack = !r_q.ack;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mail = w_q.mail;

    // R1
    store_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_req && flag_w) |=> (mail == $past(wdata)));
    // R3
    flag_low_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_req && flag_w) |=> !flag_w);
    // R4
    refuse_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !flag_w |=> $stable(mail));
    // R5
    ack_guard_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !pending_r |=> $stable(r_q.ack));
endmodule

// File: rtl/mbx_dual.sv
module mbx_dual #(
    parameter int DATA_W = 36,
    parameter int STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_mbsel,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_fifo_wr,
    output logic              mb1_flag,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_mbsel,
    input  logic [DATA_W-1:0] b_din,
    input  logic [DATA_W-1:0] fifo_q,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_fifo_rd,
    output logic              mb2_flag
);
    logic [DATA_W-1:0] mail1, mail2;
    logic a_mb_wr, a_mb_rd, b_mb_wr, b_mb_rd;

    assign a_mb_wr = a_en &&  a_wr && a_mbsel;
    assign a_mb_rd = a_en && !a_wr && a_mbsel;
    assign b_mb_wr = b_en &&  b_wr && b_mbsel;
    assign b_mb_rd = b_en && !b_wr && b_mbsel;

    // Forward mailbox: written on A, collected on B
    mbx_channel #(.DATA_W(DATA_W), .STAGES(STAGES)) i_fwd (
        .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
        .wr_req(a_mb_wr), .wdata(a_din), .rd_req(b_mb_rd),
        .mail(mail1), .flag_w(mb1_flag)
    );

    // Return mailbox: written on B, collected on A
    mbx_channel #(.DATA_W(DATA_W), .STAGES(STAGES)) i_ret (
        .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
        .wr_req(b_mb_wr), .wdata(b_din), .rd_req(a_mb_rd),
        .mail(mail2), .flag_w(mb2_flag)
    );

    assign a_fifo_wr = a_en &&  a_wr && !a_mbsel;
    assign b_fifo_rd = b_en && !b_wr && !b_mbsel;
    assign a_dout    = mail2;
    assign b_dout    = b_mbsel ? mail1 : fifo_q;

    // R8
    ret_hold_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !(b_mb_wr && mb2_flag) |=> $stable(a_dout));
    // R6
    fwd_read_keep_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        !a_mb_wr |=> $stable(mail1));
endmodule

// File: tb/test_mbx_dual.sv
module test_mbx_dual;
    localparam int W = 8;

    logic clk_a = 0, clk_b = 0, rst_n = 0;
    logic a_en = 0, a_wr = 0, a_mbsel = 0;
    logic b_en = 0, b_wr = 0, b_mbsel = 0;
    logic [W-1:0] a_din = '0, b_din = '0, fifo_q = '0;
    logic [W-1:0] a_dout, b_dout;
    logic a_fifo_wr, b_fifo_rd, mb1_flag, mb2_flag;

    int errors = 0, checks = 0;
    bit done = 0;

    always #5   clk_a = ~clk_a;
    always #6.5 clk_b = ~clk_b;

    mbx_dual #(.DATA_W(W), .STAGES(2)) i_mbx_dual (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_en(a_en), .a_wr(a_wr), .a_mbsel(a_mbsel), .a_din(a_din),
        .a_dout(a_dout), .a_fifo_wr(a_fifo_wr), .mb1_flag(mb1_flag),
        .b_en(b_en), .b_wr(b_wr), .b_mbsel(b_mbsel), .b_din(b_din),
        .fifo_q(fifo_q), .b_dout(b_dout), .b_fifo_rd(b_fifo_rd),
        .mb2_flag(mb2_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic op_a(input logic wr, input logic sel, input logic [W-1:0] d);
        @(negedge clk_a);
        a_en = 1; a_wr = wr; a_mbsel = sel; a_din = d;
        @(negedge clk_a);
        a_en = 0; a_wr = 0; a_mbsel = 0;
    endtask

    task automatic op_b(input logic wr, input logic sel, input logic [W-1:0] d);
        @(negedge clk_b);
        b_en = 1; b_wr = wr; b_mbsel = sel; b_din = d;
        @(negedge clk_b);
        b_en = 0; b_wr = 0; b_mbsel = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_a);
            @(negedge clk_b);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        // R9 reset state
        chk("R9 mb1_flag", mb1_flag, 1);
        chk("R9 mb2_flag", mb2_flag, 1);
        chk("R9 return mailbox", a_dout, 0);
        b_mbsel = 1; #1;
        chk("R9 forward mailbox", b_dout, 0);
        b_mbsel = 0;
        @(negedge clk_a); rst_n = 1;
        idle(2);

        // R10 strobes over every enable/direction/select combination
        for (int c = 0; c < 8; c++) begin
            a_en = c[0]; a_wr = c[1]; a_mbsel = c[2];
            b_en = c[0]; b_wr = c[1]; b_mbsel = c[2];
            #1;
            chk("R10 a_fifo_wr", a_fifo_wr, c[0] & c[1] & !c[2]);
            chk("R10 b_fifo_rd", b_fifo_rd, c[0] & !c[1] & !c[2]);
            a_en = 0; b_en = 0;
            #1;
        end
        a_wr = 0; a_mbsel = 0; b_wr = 0; b_mbsel = 0;

        // R7 mux with FIFO selected
        for (int v = 0; v < 256; v += 17) begin
            fifo_q = W'(v); #1;
            chk("R7 fifo path", b_dout, v);
        end

        // Forward mailbox sweep
        for (int v = 0; v < 256; v++) begin
            chk("R5 mb1 empty before", mb1_flag, 1);
            op_a(1, 1, W'(v));
            chk("R3 mb1 low after write", mb1_flag, 0);
            op_a(1, 1, ~W'(v));
            chk("R4 mb1 still low", mb1_flag, 0);
            idle(4);
            @(negedge clk_b); b_mbsel = 1; fifo_q = ~W'(v); #1;
            chk("R1/R4 forward word", b_dout, v);
            op_b(0, 1, '0);
            b_mbsel = 1; #1;
            chk("R6 forward word kept", b_dout, v);
            b_mbsel = 0; #1;
            chk("R7 fifo path", b_dout, (~v) & 8'hff);
            idle(4);
            chk("R5 mb1 high after read", mb1_flag, 1);
        end

        // Return mailbox sweep
        for (int v = 0; v < 256; v++) begin
            chk("R5 mb2 empty before", mb2_flag, 1);
            op_b(1, 1, W'(v));
            chk("R3 mb2 low after write", mb2_flag, 0);
            op_b(1, 1, ~W'(v));
            chk("R4 mb2 still low", mb2_flag, 0);
            idle(4);
            chk("R2/R8 return word", a_dout, v);
            op_a(0, 1, '0);
            chk("R6 return word kept", a_dout, v);
            idle(4);
            chk("R5 mb2 high after read", mb2_flag, 1);
        end

        // R5 read with nothing waiting has no effect; next write still accepted
        op_b(0, 1, '0);
        idle(4);
        chk("R5 mb1 idle read", mb1_flag, 1);
        op_a(1, 1, 8'h5a);
        chk("R3 mb1 low", mb1_flag, 0);
        idle(4);
        b_mbsel = 1; #1;
        chk("R1 forward after idle read", b_dout, 8'h5a);
        b_mbsel = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule